// File: doc/BRIEF.md
# Masked Header Flow Classifier

This block maps a packet's header fields to a 16-bit flow identifier. It keeps a small table of match entries. Each entry holds a key value, a bit mask, a flow identifier and an enable bit. On each key-valid strobe the block builds a match key from the source and destination IP addresses, the source and destination ports and the protocol. It compares that key with every enabled entry in parallel. One cycle later it presents a registered result with a valid pulse. The result has three parts: a per-entry hit vector, the flow identifier chosen from the hits, and a flag telling the downstream rewriter to force the packet's TTL to zero.

Software-side logic programs the table through a burst write port. A start pulse gives a base entry and an entry count. The data beats that follow fill consecutive entries, beginning at the base. Beats beyond the count or beyond the last entry are dropped. A miss returns a fixed default flow identifier of 1. Flow identifier 0 is reserved to mark packets that must be discarded by TTL expiry downstream.

Top module: `flow_classifier`

## Requirements
- R1: After reset the outputs are out_valid_o=0, hit_vec_o=0, flow_id_o=1 and ttl_clear_o=0. Every table entry is disabled, so the first key after reset misses.
- R2: The key is {src_ip[111:80], dst_ip[79:48], src_port[47:32], dst_port[31:16], proto[15:8], 8'h00[7:0]}. A key bit takes part in the compare only where the entry's mask bit is 1, and it must then equal the entry's value bit. Where the mask bit is 0 the key bit does not matter.
- R3: out_valid_o pulses exactly one cycle after each cycle in which key_valid_i is 1, and only then.
- R4: hit_vec_o bit i is 1 when entry i is enabled and matches the key. A disabled entry never sets its bit.
- R5: When several entries hit, flow_id_o is the flow identifier of the lowest-indexed hit entry.
- R6: When no entry hits, flow_id_o is 1.
- R7: ttl_clear_o is 1 exactly when flow_id_o is 0.
- R8: A cycle with wr_start_i=1 loads a base entry and a count, and carries no data. Each following cycle with wr_beat_i=1 writes the next entry, starting at the base, until the count is used up. Beats after the count is used up, beats that would pass the last entry, and beats with no burst open are ignored. A new start aborts an open burst.
- R9: A beat written in cycle t is seen by keys presented in cycle t+1 and later. A key presented in cycle t still sees the old entry.
- R10: Each beat sets the written entry's enable from wr_enable_i. A beat with wr_enable_i=0 disables that entry.
- R11: flow_id_o, hit_vec_o and ttl_clear_o hold their values in cycles where out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | Header fields are valid this cycle |
| src_ip_i | input | 32 | Source IP address |
| dst_ip_i | input | 32 | Destination IP address |
| src_port_i | input | 16 | Source port |
| dst_port_i | input | 16 | Destination port |
| proto_i | input | 8 | IP protocol number |
| wr_start_i | input | 1 | Opens a write burst |
| wr_base_i | input | 2 | First entry of the burst |
| wr_count_i | input | 3 | Number of entries in the burst |
| wr_beat_i | input | 1 | One entry's data is valid this cycle |
| wr_enable_i | input | 1 | Enable bit for the written entry |
| wr_value_i | input | 112 | Key value for the written entry |
| wr_mask_i | input | 112 | Compare mask for the written entry (1 = compare) |
| wr_flow_i | input | 16 | Flow identifier for the written entry |
| out_valid_o | output | 1 | Result valid pulse |
| flow_id_o | output | 16 | Selected flow identifier |
| hit_vec_o | output | 4 | Per-entry hit vector |
| ttl_clear_o | output | 1 | Force TTL to zero for this packet |

## Verification
The table is loaded with four overlapping entries: a protocol-only match, an exact destination match, a source prefix match and a full wildcard. The key patterns are chosen so that each selects a different lowest hit. This separates priority from mere matching, and it shows that masked-out bits are ignored while a single differing bit under the mask defeats a match. Further patterns test burst edges: a count that runs past the last entry, stray beats outside a burst, and a disabling write. Another pattern presents a key in the same cycle as a write to the entry it hits, which tells old-content from new-content timing. A long stretch of random keys drawn from a small pool, mixed with random bursts, is then compared on every clock against a behavioural model. This catches holding and valid-timing faults.

// File: rtl/flow_cls_pkg.sv
package flow_cls_pkg;
  localparam int unsigned IP_W    = 32;
  localparam int unsigned PORT_W  = 16;
  localparam int unsigned PROTO_W = 8;
  localparam int unsigned HDR_W   = 2 * IP_W + 2 * PORT_W + PROTO_W;

  typedef struct packed {
    logic [IP_W-1:0]    src_ip;
    logic [IP_W-1:0]    dst_ip;
    logic [PORT_W-1:0]  src_port;
    logic [PORT_W-1:0]  dst_port;
    logic [PROTO_W-1:0] proto;
  } hdr_t;
endpackage

// File: rtl/fc_entry_table.sv
module fc_entry_table #(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned KEY_W  = 112,
  parameter int unsigned FLOW_W = 16,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_start_i,
  input  logic [IDX_W-1:0]            wr_base_i,
  input  logic [CNT_W-1:0]            wr_count_i,
  input  logic                        wr_beat_i,
  input  logic                        wr_enable_i,
  input  logic [KEY_W-1:0]            wr_value_i,
  input  logic [KEY_W-1:0]            wr_mask_i,
  input  logic [FLOW_W-1:0]           wr_flow_i,
  output logic [N_ENT-1:0][KEY_W-1:0] value_o,
  output logic [N_ENT-1:0][KEY_W-1:0] mask_o,
  output logic [N_ENT-1:0][FLOW_W-1:0] flow_o,
  output logic [N_ENT-1:0]            enable_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_ENT - 1);

  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W-1:0] rem_q;
  logic             wr_fire;

  // a beat is accepted only while a burst is open
  assign wr_fire = wr_beat_i && !wr_start_i && (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      rem_q <= '0;
    end else if (wr_start_i) begin
      ptr_q <= CNT_W'(wr_base_i);
      rem_q <= wr_count_i;
    end else if (wr_fire) begin
      ptr_q <= ptr_q + 1'b1;
      rem_q <= (ptr_q == LAST) ? '0 : rem_q - 1'b1;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic sel;
    assign sel = wr_fire && (ptr_q == CNT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        value_o[g]  <= '0;
        mask_o[g]   <= '0;
        flow_o[g]   <= '0;
        enable_o[g] <= 1'b0;
      end else if (sel) begin
        value_o[g]  <= wr_value_i;
        mask_o[g]   <= wr_mask_i;
        flow_o[g]   <= wr_flow_i;
        enable_o[g] <= wr_enable_i;
      end
    end
  end
endmodule

// File: rtl/fc_match_array.sv
module fc_match_array #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned KEY_W = 112
) (
  input  logic [KEY_W-1:0]             key_i,
  input  logic [N_ENT-1:0][KEY_W-1:0]  value_i,
  input  logic [N_ENT-1:0][KEY_W-1:0]  mask_i,
  input  logic [N_ENT-1:0]             enable_i,
  output logic [N_ENT-1:0]             hit_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_o[g] = enable_i[g] && (((key_i ^ value_i[g]) & mask_i[g]) == '0);
  end
endmodule

// File: rtl/fc_prio_pick.sv
module fc_prio_pick #(
  parameter int unsigned N_ENT    = 4,
  parameter int unsigned FLOW_W   = 16,
  parameter logic [FLOW_W-1:0] MISS_FLOW = 1
) (
  input  logic [N_ENT-1:0]             hit_i,
  input  logic [N_ENT-1:0][FLOW_W-1:0] flow_i,
  output logic [FLOW_W-1:0]            flow_o
);
  // walk down so the lowest index wins
  always_comb begin
    flow_o = MISS_FLOW;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_i[i]) flow_o = flow_i[i];
    end
  end
endmodule

// File: rtl/flow_classifier.sv
module flow_classifier
  import flow_cls_pkg::*;
#(
  parameter int unsigned N_ENT     = 4,
  parameter int unsigned KEY_W     = 112,
  parameter int unsigned FLOW_W    = 16,
  parameter logic [FLOW_W-1:0] MISS_FLOW = 1,
  localparam int unsigned IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int unsigned CNT_W    = IDX_W + 1,
  localparam int unsigned PAD_W    = KEY_W - HDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [31:0]       src_ip_i,
  input  logic [31:0]       dst_ip_i,
  input  logic [15:0]       src_port_i,
  input  logic [15:0]       dst_port_i,
  input  logic [7:0]        proto_i,
  input  logic              wr_start_i,
  input  logic [IDX_W-1:0]  wr_base_i,
  input  logic [CNT_W-1:0]  wr_count_i,
  input  logic              wr_beat_i,
  input  logic              wr_enable_i,
  input  logic [KEY_W-1:0]  wr_value_i,
  input  logic [KEY_W-1:0]  wr_mask_i,
  input  logic [FLOW_W-1:0] wr_flow_i,
  output logic              out_valid_o,
  output logic [FLOW_W-1:0] flow_id_o,
  output logic [N_ENT-1:0]  hit_vec_o,
  output logic              ttl_clear_o
);
  hdr_t                         hdr;
  logic [KEY_W-1:0]             key;
  logic [N_ENT-1:0][KEY_W-1:0]  ent_value;
  logic [N_ENT-1:0][KEY_W-1:0]  ent_mask;
  logic [N_ENT-1:0][FLOW_W-1:0] ent_flow;
  logic [N_ENT-1:0]             ent_valid;
  logic [N_ENT-1:0]             hit;
  logic [FLOW_W-1:0]            pick;

  assign hdr = '{src_ip: src_ip_i, dst_ip: dst_ip_i, src_port: src_port_i,
                 dst_port: dst_port_i, proto: proto_i};

  if (PAD_W > 0) begin : g_pad
    assign key = {hdr, {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign key = KEY_W'(hdr);
  end

  fc_entry_table #(.N_ENT(N_ENT), .KEY_W(KEY_W), .FLOW_W(FLOW_W)) u_table (
    .clk_i, .rst_ni,
    .wr_start_i, .wr_base_i, .wr_count_i, .wr_beat_i, .wr_enable_i,
    .wr_value_i, .wr_mask_i, .wr_flow_i,
    .value_o(ent_value), .mask_o(ent_mask), .flow_o(ent_flow), .enable_o(ent_valid)
  );

  fc_match_array #(.N_ENT(N_ENT), .KEY_W(KEY_W)) u_match (
    .key_i(key), .value_i(ent_value), .mask_i(ent_mask),
    .enable_i(ent_valid), .hit_o(hit)
  );

  fc_prio_pick #(.N_ENT(N_ENT), .FLOW_W(FLOW_W), .MISS_FLOW(MISS_FLOW)) u_pick (
    .hit_i(hit), .flow_i(ent_flow), .flow_o(pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      flow_id_o   <= MISS_FLOW;
      hit_vec_o   <= '0;
      ttl_clear_o <= (MISS_FLOW == '0);
    end else begin
      out_valid_o <= key_valid_i;
      if (key_valid_i) begin
        flow_id_o   <= pick;
        hit_vec_o   <= hit;
        ttl_clear_o <= (pick == '0);
      end
    end
  end
endmodule

// File: rtl/flow_classifier_chk.sv
module flow_classifier_chk #(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned FLOW_W = 16,
  parameter logic [FLOW_W-1:0] MISS_FLOW = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_valid_i,
  input logic              out_valid_o,
  input logic [FLOW_W-1:0] flow_id_o,
  input logic [N_ENT-1:0]  hit_vec_o,
  input logic              ttl_clear_o,
  input logic [N_ENT-1:0]  ent_valid
);
  AST_VALID_AFTER_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i |=> out_valid_o); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_i |=> !out_valid_o); // R3
  AST_TTL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ttl_clear_o == (flow_id_o == '0)); // R7
  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && hit_vec_o == '0) |-> flow_id_o == MISS_FLOW); // R6
  AST_DISABLED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i |=> (hit_vec_o & ~$past(ent_valid)) == '0); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(flow_id_o) && $stable(hit_vec_o) && $stable(ttl_clear_o))); // R11
endmodule

bind flow_classifier flow_classifier_chk #(.N_ENT(N_ENT), .FLOW_W(FLOW_W), .MISS_FLOW(MISS_FLOW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .key_valid_i(key_valid_i), .out_valid_o(out_valid_o),
  .flow_id_o(flow_id_o), .hit_vec_o(hit_vec_o), .ttl_clear_o(ttl_clear_o), .ent_valid(ent_valid)
);

// File: tb/sim_flow_classifier.sv
`timescale 1ns/1ps
module sim_flow_classifier;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_valid = 1'b0;
  logic [31:0]  src_ip = '0, dst_ip = '0;
  logic [15:0]  src_port = '0, dst_port = '0;
  logic [7:0]   proto = '0;
  logic         wr_start = 1'b0, wr_beat = 1'b0, wr_enable = 1'b0;
  logic [1:0]   wr_base = '0;
  logic [2:0]   wr_count = '0;
  logic [111:0] wr_value = '0, wr_mask = '0;
  logic [15:0]  wr_flow = '0;
  logic         out_valid, ttl_clear;
  logic [15:0]  flow_id;
  logic [3:0]   hit_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  flow_classifier u0 (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(key_valid),
    .src_ip_i(src_ip), .dst_ip_i(dst_ip), .src_port_i(src_port), .dst_port_i(dst_port),
    .proto_i(proto), .wr_start_i(wr_start), .wr_base_i(wr_base), .wr_count_i(wr_count),
    .wr_beat_i(wr_beat), .wr_enable_i(wr_enable), .wr_value_i(wr_value), .wr_mask_i(wr_mask),
    .wr_flow_i(wr_flow), .out_valid_o(out_valid), .flow_id_o(flow_id), .hit_vec_o(hit_vec),
    .ttl_clear_o(ttl_clear)
  );

  // behavioural reference
  logic [111:0] m_val [N];
  logic [111:0] m_msk [N];
  logic [15:0]  m_flw [N];
  bit           m_en  [N];
  int           m_ptr, m_rem;
  bit           e_valid;
  logic [15:0]  e_flow;
  logic [3:0]   e_hit;

  function automatic logic [111:0] mk_key(logic [31:0] s, logic [31:0] d,
                                          logic [15:0] sp, logic [15:0] dp, logic [7:0] p);
    return {s, d, sp, dp, p, 8'h00};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_flw[i] = '0; end
      m_ptr = 0; m_rem = 0; e_valid = 0; e_flow = 16'd1; e_hit = '0;
    end else begin
      e_valid = key_valid;
      if (key_valid) begin
        logic [111:0] k;
        bit found;
        k = mk_key(src_ip, dst_ip, src_port, dst_port, proto);
        found = 0; e_flow = 16'd1; e_hit = '0;
        for (int i = 0; i < N; i++) begin
          if (m_en[i] && ((k & m_msk[i]) == (m_val[i] & m_msk[i]))) begin
            e_hit[i] = 1'b1;
            if (!found) begin e_flow = m_flw[i]; found = 1; end
          end
        end
      end
      if (wr_start) begin
        m_ptr = wr_base; m_rem = wr_count;
      end else if (wr_beat && m_rem > 0) begin
        if (m_ptr < N) begin
          m_val[m_ptr] = wr_value; m_msk[m_ptr] = wr_mask;
          m_flw[m_ptr] = wr_flow;  m_en[m_ptr]  = wr_enable;
          m_ptr++; m_rem--;
        end else m_rem = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 out_valid", {31'b0, out_valid}, {31'b0, e_valid});
      chk("R4 hit_vec", {28'b0, hit_vec}, {28'b0, e_hit});
      chk("R5 flow_id", {16'b0, flow_id}, {16'b0, e_flow});
      chk("R7 ttl_clear", {31'b0, ttl_clear}, {31'b0, e_flow == 16'd0});
    end
  end

  task automatic idle(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_key(logic [31:0] s, logic [31:0] d, logic [15:0] sp, logic [15:0] dp, logic [7:0] p);
    key_valid = 1'b1; src_ip = s; dst_ip = d; src_port = sp; dst_port = dp; proto = p;
  endtask

  task automatic send_key(logic [31:0] s, logic [31:0] d, logic [15:0] sp, logic [15:0] dp, logic [7:0] p);
    set_key(s, d, sp, dp, p);
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic start(logic [1:0] b, logic [2:0] c);
    wr_start = 1'b1; wr_base = b; wr_count = c;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic set_beat(bit en, logic [111:0] v, logic [111:0] m, logic [15:0] f);
    wr_beat = 1'b1; wr_enable = en; wr_value = v; wr_mask = m; wr_flow = f;
  endtask

  task automatic beat(bit en, logic [111:0] v, logic [111:0] m, logic [15:0] f);
    set_beat(en, v, m, f);
    @(negedge clk);
    wr_beat = 1'b0;
  endtask

  localparam logic [111:0] M_PROTO  = {96'b0, 8'hFF, 8'h00};
  localparam logic [111:0] M_DST    = {32'b0, 32'hFFFF_FFFF, 48'b0};
  localparam logic [111:0] M_SRC16  = {16'hFFFF, 96'b0};

  initial begin
    #20000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 valid", {31'b0, out_valid}, 0);
    chk("R1 flow", {16'b0, flow_id}, 1);
    chk("R1 hit", {28'b0, hit_vec}, 0);
    chk("R1 ttl", {31'b0, ttl_clear}, 0);
    #1 rst_n = 1'b1;
    idle(2);
    send_key(32'h0, 32'h0, 0, 0, 8'd0);
    chk("R1 R6 first key misses", {16'b0, flow_id}, 1);
    chk("R1 hit empty", {28'b0, hit_vec}, 0);

    // program the four entries in one burst
    start(2'd0, 3'd4);
    beat(1, mk_key(0, 0, 0, 0, 8'd17), M_PROTO, 16'h0000);
    beat(1, mk_key(0, 32'h0A00_0001, 0, 0, 0), M_DST, 16'h1234);
    beat(1, mk_key(32'hC0A8_0000, 0, 0, 0, 0), M_SRC16, 16'h00C3);
    beat(1, '0, '0, 16'hBEEF);

    send_key(32'h0101_0101, 32'h0202_0202, 16'd80, 16'd443, 8'd6);
    chk("R2 wildcard only", {16'b0, flow_id}, 32'hBEEF);
    chk("R4 wildcard hit", {28'b0, hit_vec}, 4'b1000);
    send_key(32'hC0A8_0505, 32'h0A00_0001, 16'd1, 16'd2, 8'd6);
    chk("R5 lowest of three", {16'b0, flow_id}, 32'h1234);
    chk("R4 three hits", {28'b0, hit_vec}, 4'b1110);
    send_key(32'hC0A8_7777, 32'h0A00_0001, 16'd1, 16'd2, 8'd17);
    chk("R7 flow zero", {16'b0, flow_id}, 0);
    chk("R7 ttl set", {31'b0, ttl_clear}, 1);
    send_key(32'hC0A9_0505, 32'h0A00_0002, 16'd9, 16'd9, 8'd1);
    chk("R2 masked bit differs", {28'b0, hit_vec}, 4'b1000);
    send_key(32'hC0A8_FFFF, 32'h0B00_0001, 16'hFFFF, 16'hFFFF, 8'd1);
    chk("R2 prefix match", {16'b0, flow_id}, 32'h00C3);
    idle(3);
    chk("R11 held", {16'b0, flow_id}, 32'h00C3);

    // R10: disable the wildcard entry
    start(2'd3, 3'd1);
    beat(0, '0, '0, 16'h5555);
    send_key(32'h0101_0101, 32'h0202_0202, 16'd80, 16'd443, 8'd6);
    chk("R10 R6 disabled -> miss", {16'b0, flow_id}, 1);
    chk("R10 no hit", {28'b0, hit_vec}, 0);

    // R8: count past the end, then stray beats
    start(2'd2, 3'd5);
    beat(1, mk_key(0, 0, 0, 0, 8'd6), M_PROTO, 16'h0222);
    beat(1, mk_key(0, 0, 0, 0, 8'd99), M_PROTO, 16'h0333);
    beat(1, '0, '0, 16'h7777);
    beat(1, '0, '0, 16'h7778);
    send_key(32'h0, 32'h0, 0, 0, 8'd6);
    chk("R8 entry2 written", {16'b0, flow_id}, 32'h0222);
    send_key(32'h0, 32'h0, 0, 0, 8'd99);
    chk("R8 entry3 written", {16'b0, flow_id}, 32'h0333);
    send_key(32'h0, 32'h0, 0, 0, 8'd50);
    chk("R8 overflow beats dropped", {16'b0, flow_id}, 1);

    // R8: a new start aborts an open burst
    start(2'd0, 3'd2);
    start(2'd1, 3'd0);
    beat(1, '0, '0, 16'h6666);
    send_key(32'h0, 32'h0, 0, 0, 8'd50);
    chk("R8 aborted burst", {16'b0, flow_id}, 1);

    // R9: key in the write cycle sees the old entry
    start(2'd1, 3'd1);
    set_beat(1, '0, '0, 16'h0ABC);
    set_key(32'h0, 32'h0, 0, 0, 8'd50);
    @(negedge clk);
    wr_beat = 1'b0; key_valid = 1'b0;
    chk("R9 same cycle old", {16'b0, flow_id}, 1);
    send_key(32'h0, 32'h0, 0, 0, 8'd50);
    chk("R9 next cycle new", {16'b0, flow_id}, 32'h0ABC);

    // random traffic against the model
    for (int c = 0; c < 600; c++) begin
      int r;
      r = $urandom_range(0, 9);
      key_valid = ($urandom_range(0, 2) != 0);
      src_ip = ($urandom_range(0, 1) != 0) ? 32'hC0A8_0001 : 32'h0101_0101;
      dst_ip = ($urandom_range(0, 1) != 0) ? 32'h0A00_0001 : 32'h0A00_0003;
      src_port = 16'($urandom_range(0, 3));
      dst_port = 16'($urandom_range(0, 3));
      proto = 8'($urandom_range(5, 7));
      wr_start = (r == 0);
      wr_base = 2'($urandom_range(0, 3));
      wr_count = 3'($urandom_range(0, 5));
      wr_beat = (r > 5);
      wr_enable = ($urandom_range(0, 3) != 0);
      wr_value = mk_key(src_ip, dst_ip, src_port, dst_port, proto);
      case ($urandom_range(0, 3))
        0: wr_mask = M_PROTO;
        1: wr_mask = M_DST;
        2: wr_mask = M_SRC16;
        default: wr_mask = '0;
      endcase
      wr_flow = 16'($urandom_range(0, 4));
      @(negedge clk);
    end
    key_valid = 0; wr_start = 0; wr_beat = 0;
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule